// File: doc/BRIEF.md
# Indirect Management Register Access Engine

This engine lets a host reach the internal registers of a managed switch device. The device answers on one management bus address only, so its registers are reached through a command register and a data register at that address. The host presents one request at a time: a device address, a register address, a read or write flag and, for writes, a data word. The engine then runs the needed series of management bus transactions. It polls a busy flag before and after each command. When the sequence ends it returns a one-cycle completion pulse, together with read data or an error indication.

When the configured switch address is zero, the device is taken to decode every bus address itself. The engine then forwards the request unchanged as one bus transaction. The serial bit timing of the management bus is handled elsewhere. This block drives a transaction-level master port and sees each transaction end through a done pulse that carries read data and an error flag.

Top module: `imdio_engine`

## Requirements
- R1: With `sw_addr` equal to 0 at acceptance, the request produces exactly one bus transaction carrying the request's write flag, device address, register address and (for writes) data. A direct read returns the bus read data.
- R2: With a nonzero `sw_addr`, the first transactions of every request are reads of register 0 at `sw_addr`. They repeat until a read returns bit 15 clear, and only then is any other transaction issued.
- R3: A busy poll (before or after the command) that sees bit 15 set on 16 reads in a row ends the request with `rsp_err` and `rsp_timeout` high. 15 busy reads followed by a clear one do not time out.
- R4: An indirect read, after the first poll, writes the command word 0x9800 into register 0. It then polls register 0 again and finally reads register 1, whose value is returned on `rsp_rdata`.
- R5: An indirect write, after the first poll, writes the data to register 1. It then writes the command word 0x9400 into register 0 and polls register 0 until it is free.
- R6: The command word carries the device address in bits 9:5 and the register address in bits 4:0, OR-ed onto the opcode.
- R7: A bus transaction that ends with `bus_err` high ends the request on the next cycle with `rsp_err` high and `rsp_timeout` low. No further bus transaction follows.
- R8: `req_ready` is low from the cycle after acceptance until `rsp_done`. Requests presented meanwhile have no effect.
- R9: In reset `req_ready` is high and `bus_req` and `rsp_done` are low.
- R10: `rsp_done` lasts one cycle. `rsp_rdata` is 0 on writes and on any error.
- R11: While a bus transaction waits for `bus_done`, `bus_req` stays high and its write flag, address and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_addr | input | 5 | Bus address of the managed device; 0 selects direct mode |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Engine idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Target device address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request ended with an error |
| rsp_timeout | output | 1 | The error was a busy-poll timeout |
| rsp_rdata | output | 16 | Read data |
| bus_req | output | 1 | Bus transaction requested |
| bus_write | output | 1 | Bus transaction is a write |
| bus_phy | output | 5 | Bus transaction address |
| bus_reg | output | 5 | Bus transaction register |
| bus_wdata | output | 16 | Bus write data |
| bus_done | input | 1 | Bus transaction finished (one cycle) |
| bus_err | input | 1 | Bus transaction failed, valid with done |
| bus_rdata | input | 16 | Bus read data, valid with done |

## Verification
A wrong sequencer step shows at the bus port in the very next transaction: a wrong register, a wrong opcode or a missing data write. A stale poll counter shows as a timeout after the wrong number of busy reads, or as a missing timeout. The bench therefore checks every bus transaction against a queue built from the requirements as it is captured. It also checks `req_ready` on every cycle of a request. A missed abort shows as an extra transaction after an error. Wrong capture of the response shows at the single `rsp_done` cycle.

// File: rtl/imdio_pkg.sv
`timescale 1ns/1ps
package imdio_pkg;
  localparam int DEV_W    = 5;
  localparam int REG_W    = 5;
  localparam int DATA_W   = 16;
  localparam int BUSY_BIT = 15;

  localparam logic [REG_W-1:0]  CTRL_REG = 5'd0;
  localparam logic [REG_W-1:0]  DATA_REG = 5'd1;
  localparam logic [DATA_W-1:0] OP_RD    = 16'h9800;
  localparam logic [DATA_W-1:0] OP_WR    = 16'h9400;

  typedef enum logic [2:0] {
    STEP_IDLE,
    STEP_DIRECT,
    STEP_WAIT_FREE,
    STEP_PUT_DATA,
    STEP_ISSUE_CMD,
    STEP_WAIT_CMD,
    STEP_GET_DATA
  } step_e;

  typedef struct packed {
    logic              wr;
    logic [DEV_W-1:0]  dev;
    logic [REG_W-1:0]  rg;
    logic [DATA_W-1:0] wdata;
  } req_t;

  // opcode with device and register fields OR-ed in
  function automatic logic [DATA_W-1:0] cmd_word(input logic wr,
                                                 input logic [DEV_W-1:0] dev,
                                                 input logic [REG_W-1:0] rg);
    logic [DATA_W-1:0] op;
    op = wr ? OP_WR : OP_RD;
    return op | (DATA_W'(dev) << REG_W) | DATA_W'(rg);
  endfunction

  function automatic logic busy_flag(input logic [DATA_W-1:0] d);
    return d[BUSY_BIT];
  endfunction

  function automatic logic is_poll(input step_e s);
    return (s == STEP_WAIT_FREE) || (s == STEP_WAIT_CMD);
  endfunction
endpackage

// File: rtl/imdio_poll_ctr.sv
`timescale 1ns/1ps
module imdio_poll_ctr #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic busy_hit,
  output logic last_try
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (clear)    cnt <= '0;
    else if (busy_hit) cnt <= cnt + 1'b1;
  end

  // this busy read is the last one allowed
  assign last_try = busy_hit && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/imdio_seq.sv
`timescale 1ns/1ps
module imdio_seq
  import imdio_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  logic  direct,
  input  logic  is_wr,
  input  logic  bus_done,
  input  logic  bus_err,
  input  logic  busy_seen,
  input  logic  last_try,
  output step_e step,
  output logic  finish,
  output logic  fin_err,
  output logic  fin_tmo,
  output logic  grab_data
);
  step_e nxt;

  always_comb begin
    nxt       = step;
    finish    = 1'b0;
    fin_err   = 1'b0;
    fin_tmo   = 1'b0;
    grab_data = 1'b0;
    if (step == STEP_IDLE) begin
      if (accept) nxt = direct ? STEP_DIRECT : STEP_WAIT_FREE;
    end else if (bus_done) begin
      if (bus_err) begin
        nxt     = STEP_IDLE;
        finish  = 1'b1;
        fin_err = 1'b1;
      end else begin
        case (step)
          STEP_DIRECT: begin
            nxt       = STEP_IDLE;
            finish    = 1'b1;
            grab_data = !is_wr;
          end
          STEP_WAIT_FREE: begin
            if (busy_seen) begin
              if (last_try) begin
                nxt     = STEP_IDLE;
                finish  = 1'b1;
                fin_err = 1'b1;
                fin_tmo = 1'b1;
              end
            end else begin
              nxt = is_wr ? STEP_PUT_DATA : STEP_ISSUE_CMD;
            end
          end
          STEP_PUT_DATA:  nxt = STEP_ISSUE_CMD;
          STEP_ISSUE_CMD: nxt = STEP_WAIT_CMD;
          STEP_WAIT_CMD: begin
            if (busy_seen) begin
              if (last_try) begin
                nxt     = STEP_IDLE;
                finish  = 1'b1;
                fin_err = 1'b1;
                fin_tmo = 1'b1;
              end
            end else if (is_wr) begin
              nxt    = STEP_IDLE;
              finish = 1'b1;
            end else begin
              nxt = STEP_GET_DATA;
            end
          end
          STEP_GET_DATA: begin
            nxt       = STEP_IDLE;
            finish    = 1'b1;
            grab_data = 1'b1;
          end
          default: nxt = STEP_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step <= STEP_IDLE;
    else        step <= nxt;
  end
endmodule

// File: rtl/imdio_bus_drive.sv
`timescale 1ns/1ps
module imdio_bus_drive
  import imdio_pkg::*;
(
  input  step_e             step,
  input  req_t              rq,
  input  logic [DEV_W-1:0]  sw,
  output logic              bus_req,
  output logic              bus_write,
  output logic [DEV_W-1:0]  bus_phy,
  output logic [REG_W-1:0]  bus_reg,
  output logic [DATA_W-1:0] bus_wdata
);
  always_comb begin
    bus_req   = 1'b1;
    bus_write = 1'b0;
    bus_phy   = sw;
    bus_reg   = CTRL_REG;
    bus_wdata = '0;
    case (step)
      STEP_DIRECT: begin
        bus_write = rq.wr;
        bus_phy   = rq.dev;
        bus_reg   = rq.rg;
        bus_wdata = rq.wr ? rq.wdata : '0;
      end
      STEP_WAIT_FREE, STEP_WAIT_CMD: ;
      STEP_PUT_DATA: begin
        bus_write = 1'b1;
        bus_reg   = DATA_REG;
        bus_wdata = rq.wdata;
      end
      STEP_ISSUE_CMD: begin
        bus_write = 1'b1;
        bus_wdata = cmd_word(rq.wr, rq.dev, rq.rg);
      end
      STEP_GET_DATA: bus_reg = DATA_REG;
      default: begin
        bus_req = 1'b0;
        bus_phy = '0;
      end
    endcase
  end
endmodule

// File: rtl/imdio_engine.sv
`timescale 1ns/1ps
module imdio_engine
  import imdio_pkg::*;
#(
  parameter int POLL_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEV_W-1:0]  sw_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic              rsp_timeout,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req,
  output logic              bus_write,
  output logic [DEV_W-1:0]  bus_phy,
  output logic [REG_W-1:0]  bus_reg,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_done,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata
);
  step_e            step;
  req_t             rq;
  logic [DEV_W-1:0] sw_q;
  logic accept, in_poll, busy_seen, busy_hit, last_try;
  logic finish, fin_err, fin_tmo, grab_data;

  assign req_ready = (step == STEP_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_poll   = is_poll(step);
  assign busy_seen = busy_flag(bus_rdata);
  assign busy_hit  = bus_done && !bus_err && in_poll && busy_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq   <= '0;
      sw_q <= '0;
    end else if (accept) begin
      rq   <= '{wr: req_write, dev: req_dev, rg: req_reg, wdata: req_wdata};
      sw_q <= sw_addr;
    end
  end

  imdio_poll_ctr #(.LIMIT(POLL_LIMIT)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (!in_poll),
    .busy_hit (busy_hit),
    .last_try (last_try)
  );

  imdio_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .direct    (sw_addr == '0),
    .is_wr     (rq.wr),
    .bus_done  (bus_done),
    .bus_err   (bus_err),
    .busy_seen (busy_seen),
    .last_try  (last_try),
    .step      (step),
    .finish    (finish),
    .fin_err   (fin_err),
    .fin_tmo   (fin_tmo),
    .grab_data (grab_data)
  );

  imdio_bus_drive u_drv (
    .step      (step),
    .rq        (rq),
    .sw        (sw_q),
    .bus_req   (bus_req),
    .bus_write (bus_write),
    .bus_phy   (bus_phy),
    .bus_reg   (bus_reg),
    .bus_wdata (bus_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_done    <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_timeout <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_done <= finish;
      if (finish) begin
        rsp_err     <= fin_err;
        rsp_timeout <= fin_tmo;
        rsp_rdata   <= grab_data ? bus_rdata : '0;
      end
    end
  end
endmodule

// File: rtl/imdio_engine_chk.sv
`timescale 1ns/1ps
module imdio_engine_chk
  import imdio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              rsp_err,
  input logic              rsp_timeout,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              bus_req,
  input logic              bus_write,
  input logic [DEV_W-1:0]  bus_phy,
  input logic [REG_W-1:0]  bus_reg,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_done,
  input logic              bus_err,
  input logic              busy_hit
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_req);

  // R8
  accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3
  timeout_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_timeout) |-> $past(busy_hit));

  // R7
  err_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_done && bus_err) |=> (rsp_done && rsp_err && !rsp_timeout));

  // R10
  err_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> (rsp_rdata == '0));

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_phy) && $stable(bus_reg)
                                && $stable(bus_write) && $stable(bus_wdata)));
endmodule

bind imdio_engine imdio_engine_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_done    (rsp_done),
  .rsp_err     (rsp_err),
  .rsp_timeout (rsp_timeout),
  .rsp_rdata   (rsp_rdata),
  .bus_req     (bus_req),
  .bus_write   (bus_write),
  .bus_phy     (bus_phy),
  .bus_reg     (bus_reg),
  .bus_wdata   (bus_wdata),
  .bus_done    (bus_done),
  .bus_err     (bus_err),
  .busy_hit    (busy_hit)
);

// File: tb/test_imdio_engine.sv
`timescale 1ns/1ps
module test_imdio_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  sw_addr = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_dev = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done, rsp_err, rsp_timeout;
  logic [15:0] rsp_rdata;
  logic        bus_req, bus_write;
  logic [4:0]  bus_phy, bus_reg;
  logic [15:0] bus_wdata;
  logic        bus_done = 1'b0;
  logic        bus_err = 1'b0;
  logic [15:0] bus_rdata = '0;

  always #4 clk = ~clk;

  imdio_engine i_imdio_engine (
    .clk(clk), .rst_n(rst_n), .sw_addr(sw_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_timeout(rsp_timeout),
    .rsp_rdata(rsp_rdata),
    .bus_req(bus_req), .bus_write(bus_write), .bus_phy(bus_phy),
    .bus_reg(bus_reg), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  localparam int LIM = 16;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // expected bus transactions: {write, phy, reg, wdata}
  logic [26:0] exp_q[$];
  string cur_tag = "R9";

  // device model configuration
  bit          direct_mode;
  int          busy_left, busy_post, err_at, lat, txn_idx;
  logic [4:0]  cur_sw;
  logic [15:0] fetch_val;

  function automatic logic [15:0] direct_val(input logic [4:0] p, input logic [4:0] r);
    return {p, r, 6'h2B};
  endfunction

  // transaction-level device on the bus
  initial begin
    bit active = 0;
    int wait_left = 0;
    bit r_err = 0;
    logic [15:0] r_data = '0;
    logic [26:0] seen = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        bus_done = 0; bus_err = 0; active = 0;
        continue;
      end
      if (bus_done) begin
        bus_done = 0; bus_err = 0; bus_rdata = '0;
      end else if (active) begin
        wait_left--;
        if (wait_left <= 0) begin
          check(bus_req && ({bus_write, bus_phy, bus_reg, bus_wdata} == seen),
                "R11", "bus held", {5'd0, bus_write, bus_phy, bus_reg, bus_wdata}, {5'd0, seen});
          bus_done = 1; bus_err = r_err; bus_rdata = r_data; active = 0;
        end
      end
      if (!active && !bus_done && bus_req) begin
        seen = {bus_write, bus_phy, bus_reg, bus_wdata};
        if (exp_q.size() == 0)
          check(0, cur_tag, "unexpected bus txn", {5'd0, seen}, 32'hFFFFFFFF);
        else begin
          logic [26:0] e;
          e = exp_q.pop_front();
          check(seen == e, cur_tag, "bus txn", {5'd0, seen}, {5'd0, e});
        end
        r_err = (txn_idx == err_at);
        r_data = '0;
        if (direct_mode) r_data = bus_write ? 16'h0 : direct_val(bus_phy, bus_reg);
        else if (bus_reg == 5'd0 && !bus_write) begin
          if (busy_left > 0) begin r_data = 16'hFFFF; busy_left--; end
          else r_data = 16'h7FFF;
        end else if (bus_reg == 5'd0 && bus_write) busy_left = busy_post;
        else if (bus_reg == 5'd1 && !bus_write) r_data = fetch_val;
        if (r_err) r_data = '0;
        txn_idx++;
        active = 1; wait_left = lat;
        if (wait_left <= 0) begin
          bus_done = 1; bus_err = r_err; bus_rdata = r_data; active = 0;
        end
      end
    end
  end

  // reference model state
  int m_k; bit m_stop, m_err, m_tmo;

  task automatic add(input logic [26:0] e);
    if (m_stop) return;
    exp_q.push_back(e);
    if (m_k == err_at) begin m_stop = 1; m_err = 1; end
    m_k++;
  endtask

  task automatic model_poll(input int busy_n);
    for (int i = 0; i < LIM; i++) begin
      add({1'b0, cur_sw, 5'd0, 16'd0});
      if (m_stop) return;
      if (i >= busy_n) return;
    end
    m_tmo = 1; m_stop = 1;
  endtask

  task automatic run(input string tag, input bit w, input logic [4:0] dev,
                     input logic [4:0] rg, input logic [15:0] wd,
                     input logic [4:0] sw, input int bpre, input int bpost,
                     input int errk, input int latency, input int hold,
                     input logic [15:0] fval);
    logic [15:0] e_rdata;
    bit e_err;
    int cnt;
    bit ready_bad;
    cur_tag = tag; cur_sw = sw; direct_mode = (sw == 0);
    busy_left = bpre; busy_post = bpost; err_at = errk; lat = latency;
    txn_idx = 0; fetch_val = fval;
    exp_q.delete();
    m_k = 0; m_stop = 0; m_err = 0; m_tmo = 0;
    if (sw == 0) add({w, dev, rg, w ? wd : 16'h0});
    else begin
      model_poll(bpre);
      if (w) add({1'b1, sw, 5'd1, wd});
      add({1'b1, sw, 5'd0, (w ? 16'h9400 : 16'h9800) + 16'(dev) * 16'd32 + 16'(rg)});
      if (!m_stop) model_poll(bpost);
      if (!w) add({1'b0, sw, 5'd1, 16'd0});
    end
    e_err = m_err || m_tmo;
    e_rdata = (e_err || w) ? 16'h0 : ((sw == 0) ? direct_val(dev, rg) : fval);

    @(negedge clk);
    sw_addr = sw; req_valid = 1; req_write = w; req_dev = dev; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = (hold > 0);
    req_write = ~w; req_dev = ~dev; req_reg = rg ^ 5'h15; req_wdata = 16'hDEAD;
    cnt = 0; ready_bad = 0;
    while (!rsp_done && cnt < 3000) begin
      if (req_ready) ready_bad = 1;
      cnt++;
      if (cnt >= hold) req_valid = 0;
      @(negedge clk);
    end
    req_valid = 0;
    check(!ready_bad, "R8", "req_ready low while busy", {31'd0, ready_bad}, 0);
    check(rsp_done, tag, "rsp_done seen", {31'd0, rsp_done}, 1);
    check(rsp_err == e_err, (m_err ? "R7" : tag), "rsp_err", {31'd0, rsp_err}, {31'd0, e_err});
    check(rsp_timeout == m_tmo, "R3", "rsp_timeout", {31'd0, rsp_timeout}, {31'd0, m_tmo});
    check(rsp_rdata == e_rdata, "R10", "rsp_rdata", {16'd0, rsp_rdata}, {16'd0, e_rdata});
    check(exp_q.size() == 0, tag, "bus txns missing", exp_q.size(), 0);
    @(negedge clk);
    check(!rsp_done, "R10", "done single cycle", {31'd0, rsp_done}, 0);
    check(!bus_req, "R7", "bus quiet after done", {31'd0, bus_req}, 0);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1, "R9", "ready in reset", {31'd0, req_ready}, 1);
    check(bus_req == 0, "R9", "bus_req in reset", {31'd0, bus_req}, 0);
    check(rsp_done == 0, "R9", "rsp_done in reset", {31'd0, rsp_done}, 0);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1 && bus_req == 0, "R9", "idle after reset",
          {30'd0, req_ready, bus_req}, 2);

    // direct mode
    run("R1", 0, 5'd3, 5'd7, 16'h0, 5'd0, 0, 0, -1, 1, 0, 16'h0);
    run("R1", 1, 5'h1F, 5'h1F, 16'hA55A, 5'd0, 0, 0, -1, 0, 0, 16'h0);
    run("R7", 0, 5'd2, 5'd4, 16'h0, 5'd0, 0, 0, 0, 2, 0, 16'h0);
    // indirect read and write sequences
    run("R4", 0, 5'h04, 5'h0A, 16'h0, 5'h11, 0, 0, -1, 0, 2, 16'hBEEF);
    run("R6", 0, 5'h1F, 5'h1F, 16'h0, 5'h11, 3, 5, -1, 2, 2, 16'h1234);
    run("R5", 1, 5'h09, 5'h16, 16'hC3C3, 5'h11, 2, 1, -1, 1, 2, 16'h0);
    run("R6", 1, 5'h00, 5'h00, 16'h0001, 5'h11, 0, 0, -1, 0, 0, 16'h0);
    run("R2", 1, 5'h15, 5'h03, 16'h7E81, 5'h02, 4, 0, -1, 0, 2, 16'h0);
    // busy poll limit
    run("R3", 0, 5'd1, 5'd2, 16'h0, 5'h11, 16, 0, -1, 0, 2, 16'h0);
    run("R3", 0, 5'd1, 5'd2, 16'h0, 5'h11, 15, 0, -1, 0, 2, 16'h5A5A);
    run("R3", 1, 5'd6, 5'd8, 16'h00FF, 5'h11, 0, 20, -1, 1, 2, 16'h0);
    // bus errors abort
    run("R7", 1, 5'd6, 5'd8, 16'h00FF, 5'h11, 0, 0, 2, 0, 2, 16'h0);
    run("R7", 0, 5'd6, 5'd8, 16'h0, 5'h11, 2, 0, 1, 1, 2, 16'h0);
    run("R7", 0, 5'd6, 5'd8, 16'h0, 5'h11, 0, 0, 3, 0, 2, 16'h0);
    // back to direct mode
    run("R1", 0, 5'd17, 5'd30, 16'h0, 5'd0, 0, 0, -1, 3, 0, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule